// File: doc/BRIEF.md
# Gate-A20 Command Sequence Trap

This block sits on the host I/O path in front of a legacy keyboard controller. It watches each cycle aimed at the data port (60h) or the command/status port (64h). It follows the three-step gate-A20 command sequence with a small state machine that has three states: idle, command seen, and data seen. For every cycle it makes two decisions. The first is whether the cycle is forwarded to the downstream controller. The second is whether a system-management interrupt (SMI) pulse is raised. While a sequence is open it holds a level flag that says the sequence is pending.

An 8-bit configuration value chooses how each kind of malformed or out-of-sequence cycle is treated. Each governing bit has one meaning. When the bit is set, the cycle is trapped (not forwarded) and an SMI is raised. When the bit is clear, the cycle is forwarded and no SMI is raised. The bits are:
- bit 0 governs data-port reads.
- bit 1 governs data-port writes.
- bit 2 governs status reads.
- bit 3 governs command writes.

Bit 7 adds an SMI on every return from an open sequence to idle.

Decisions are registered. `fwd_o` and `smi_o` are one-clock pulses in the clock after the edge that samples `cyc_valid_i`. `pend_o` changes on that same edge.

Top module: `a20_gate_trap`

## Requirements
- R1: While `rst_ni` is low and in the first clock after it rises, the machine is idle, and `pend_o`, `fwd_o` and `smi_o` are all 0.
- R2: In idle, a write (`wr_i`=1) to port 64h (`port_sel_i`=1) of data D1h opens the sequence: `pend_o` goes to 1, the cycle is forwarded, and no SMI is raised.
- R3: In idle, every other cycle leaves the machine idle. The governing bit is bit 1 for a data write (`port_sel_i`=0, `wr_i`=1), bit 0 for a data read, bit 3 for a command write other than D1h, and bit 2 for a status read (`port_sel_i`=1, `wr_i`=0).
- R4: After D1h, a write to port 60h moves to the data-seen state. It is forwarded, raises no SMI, and keeps `pend_o` at 1.
- R5: After D1h, a repeated D1h command write is always forwarded and never raises an SMI, whatever the configuration. The machine stays in the command-seen state with `pend_o` at 1.
- R6: After D1h, a command write other than D1h returns to idle, with bit 3 governing the cycle.
- R7: After D1h, a read of port 60h returns to idle, with bit 0 governing the cycle.
- R8: While a sequence is open, a status read keeps the current state and `pend_o` at 1, with bit 2 governing the cycle.
- R9: In the data-seen state, a command write of FFh closes the sequence normally. It is always forwarded, the machine returns to idle, and the SMI equals bit 7.
- R10: In the data-seen state, a command write other than FFh returns to idle, with bit 3 governing the cycle.
- R11: In the data-seen state, a further write to port 60h returns to idle, with bit 1 governing the cycle.
- R12: In the data-seen state, a read of port 60h returns to idle, with bit 0 governing the cycle.
- R13: On every return from an open sequence to idle, an SMI is also raised when bit 7 is set, in addition to any SMI from the governing bit.
- R14: `fwd_o` and `smi_o` pulse for exactly one clock, in the clock after the edge that samples `cyc_valid_i`=1. With `cyc_valid_i`=0 they stay 0 and `pend_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_valid_i | input | 1 | A host cycle to port 60h/64h is present this clock |
| port_sel_i | input | 1 | 0 = port 60h, 1 = port 64h |
| wr_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 8 | Write data byte |
| cfg_i | input | 8 | Trap configuration value |
| fwd_o | output | 1 | Pulse: cycle is passed to the keyboard controller |
| smi_o | output | 1 | Pulse: system-management interrupt request |
| pend_o | output | 1 | A gate-A20 sequence is open |

## Verification
The hardest cases to reach are the exits from the data-seen state, because they only follow a D1h command write and then a data write. Uniform random cycles would seldom line these up. The random stimulus therefore weights command writes of D1h, data writes and FFh command writes heavily, and draws a fresh configuration for every cycle so that each governing bit is seen both set and clear on each path. A directed prologue first walks every transition once, with bit 7 both set and clear.

// File: rtl/a20_trap_pkg.sv
package a20_trap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GATE1 = 2'd1,
    ST_GATE2 = 2'd2
  } seq_state_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_WR_CMD_ENTER,
    EV_WR_CMD_EXIT,
    EV_WR_CMD_OTHER,
    EV_WR_DATA,
    EV_RD_DATA,
    EV_RD_STATUS
  } cyc_ev_e;

  // governing-bit vector order used inside the block
  localparam int unsigned GOV_RD_DATA   = 0;
  localparam int unsigned GOV_WR_DATA   = 1;
  localparam int unsigned GOV_RD_STATUS = 2;
  localparam int unsigned GOV_WR_CMD    = 3;
  localparam int unsigned GOV_EXIT_SMI  = 4;
  localparam int unsigned GOV_W         = 5;

  typedef struct packed {
    seq_state_e nxt;
    logic       fwd;
    logic       smi;
  } verdict_t;

endpackage

// File: rtl/a20_cyc_decode.sv
module a20_cyc_decode
  import a20_trap_pkg::*;
#(
  parameter int unsigned       DATA_W    = 8,
  parameter logic [DATA_W-1:0] ENTER_CMD = 8'hD1,
  parameter logic [DATA_W-1:0] EXIT_CMD  = 8'hFF
) (
  input  logic              cyc_valid_i,
  input  logic              port_sel_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cyc_ev_e           ev_o
);

  always_comb begin
    ev_o = EV_NONE;
    if (cyc_valid_i) begin
      unique case ({port_sel_i, wr_i})
        2'b00: ev_o = EV_RD_DATA;
        2'b01: ev_o = EV_WR_DATA;
        2'b10: ev_o = EV_RD_STATUS;
        default: begin
          if (wdata_i == ENTER_CMD)     ev_o = EV_WR_CMD_ENTER;
          else if (wdata_i == EXIT_CMD) ev_o = EV_WR_CMD_EXIT;
          else                          ev_o = EV_WR_CMD_OTHER;
        end
      endcase
    end
  end

endmodule

// File: rtl/a20_trap_policy.sv
module a20_trap_policy
  import a20_trap_pkg::*;
(
  input  seq_state_e       state_i,
  input  cyc_ev_e          ev_i,
  input  logic [GOV_W-1:0] gov_i,
  output verdict_t         verdict_o
);

  // governed outcome: trapped with SMI when the bit is set
  function automatic verdict_t governed(input seq_state_e nxt, input logic gbit,
                                        input logic is_exit, input logic exit_smi);
    verdict_t v;
    v.nxt = nxt;
    v.fwd = ~gbit;
    v.smi = gbit | (is_exit & exit_smi);
    return v;
  endfunction

  function automatic verdict_t pass(input seq_state_e nxt, input logic smi);
    verdict_t v;
    v.nxt = nxt;
    v.fwd = 1'b1;
    v.smi = smi;
    return v;
  endfunction

  logic g_rd_data, g_wr_data, g_rd_stat, g_wr_cmd, g_exit;
  assign g_rd_data = gov_i[GOV_RD_DATA];
  assign g_wr_data = gov_i[GOV_WR_DATA];
  assign g_rd_stat = gov_i[GOV_RD_STATUS];
  assign g_wr_cmd  = gov_i[GOV_WR_CMD];
  assign g_exit    = gov_i[GOV_EXIT_SMI];

  always_comb begin
    verdict_o.nxt = state_i;
    verdict_o.fwd = 1'b0;
    verdict_o.smi = 1'b0;
    unique case (state_i)
      ST_GATE1: begin
        unique case (ev_i)
          EV_WR_CMD_ENTER: verdict_o = pass(ST_GATE1, 1'b0);  // double trigger
          EV_WR_CMD_EXIT,
          EV_WR_CMD_OTHER: verdict_o = governed(ST_IDLE, g_wr_cmd, 1'b1, g_exit);
          EV_WR_DATA:      verdict_o = pass(ST_GATE2, 1'b0);
          EV_RD_DATA:      verdict_o = governed(ST_IDLE, g_rd_data, 1'b1, g_exit);
          EV_RD_STATUS:    verdict_o = governed(ST_GATE1, g_rd_stat, 1'b0, g_exit);
          default: ;
        endcase
      end
      ST_GATE2: begin
        unique case (ev_i)
          EV_WR_CMD_EXIT:  verdict_o = pass(ST_IDLE, g_exit);
          EV_WR_CMD_ENTER,
          EV_WR_CMD_OTHER: verdict_o = governed(ST_IDLE, g_wr_cmd, 1'b1, g_exit);
          EV_WR_DATA:      verdict_o = governed(ST_IDLE, g_wr_data, 1'b1, g_exit);
          EV_RD_DATA:      verdict_o = governed(ST_IDLE, g_rd_data, 1'b1, g_exit);
          EV_RD_STATUS:    verdict_o = governed(ST_GATE2, g_rd_stat, 1'b0, g_exit);
          default: ;
        endcase
      end
      default: begin
        verdict_o.nxt = ST_IDLE;
        unique case (ev_i)
          EV_WR_CMD_ENTER: verdict_o = pass(ST_GATE1, 1'b0);
          EV_WR_CMD_EXIT,
          EV_WR_CMD_OTHER: verdict_o = governed(ST_IDLE, g_wr_cmd, 1'b0, g_exit);
          EV_WR_DATA:      verdict_o = governed(ST_IDLE, g_wr_data, 1'b0, g_exit);
          EV_RD_DATA:      verdict_o = governed(ST_IDLE, g_rd_data, 1'b0, g_exit);
          EV_RD_STATUS:    verdict_o = governed(ST_IDLE, g_rd_stat, 1'b0, g_exit);
          default: ;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/a20_seq_reg.sv
module a20_seq_reg
  import a20_trap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  verdict_t   verdict_i,
  output seq_state_e state_o,
  output logic       fwd_o,
  output logic       smi_o,
  output logic       pend_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      fwd_o   <= 1'b0;
      smi_o   <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      state_o <= verdict_i.nxt;
      fwd_o   <= verdict_i.fwd;
      smi_o   <= verdict_i.smi;
      pend_o  <= (verdict_i.nxt != ST_IDLE);
    end
  end

endmodule

// File: rtl/a20_gate_trap.sv
module a20_gate_trap
  import a20_trap_pkg::*;
#(
  parameter int unsigned       DATA_W        = 8,
  parameter int unsigned       CFG_W         = 8,
  parameter logic [DATA_W-1:0] ENTER_CMD     = 8'hD1,
  parameter logic [DATA_W-1:0] EXIT_CMD      = 8'hFF,
  parameter int unsigned       BIT_RD_DATA   = 0,
  parameter int unsigned       BIT_WR_DATA   = 1,
  parameter int unsigned       BIT_RD_STATUS = 2,
  parameter int unsigned       BIT_WR_CMD    = 3,
  parameter int unsigned       BIT_EXIT_SMI  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_valid_i,
  input  logic              port_sel_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic              fwd_o,
  output logic              smi_o,
  output logic              pend_o
);

  localparam int unsigned MAX_BIT = CFG_W - 1;

  generate
    if (BIT_RD_DATA > MAX_BIT || BIT_WR_DATA > MAX_BIT || BIT_RD_STATUS > MAX_BIT ||
        BIT_WR_CMD > MAX_BIT || BIT_EXIT_SMI > MAX_BIT) begin : g_bad_cfg_bit
      $error("a20_gate_trap: governing bit index outside cfg_i");
    end
  endgenerate

  logic [GOV_W-1:0] gov;
  logic             unused_cfg;
  cyc_ev_e          ev;
  seq_state_e       state_q;
  verdict_t         verdict;

  assign gov[GOV_RD_DATA]   = cfg_i[BIT_RD_DATA];
  assign gov[GOV_WR_DATA]   = cfg_i[BIT_WR_DATA];
  assign gov[GOV_RD_STATUS] = cfg_i[BIT_RD_STATUS];
  assign gov[GOV_WR_CMD]    = cfg_i[BIT_WR_CMD];
  assign gov[GOV_EXIT_SMI]  = cfg_i[BIT_EXIT_SMI];
  assign unused_cfg         = ^cfg_i;

  a20_cyc_decode #(
    .DATA_W   (DATA_W),
    .ENTER_CMD(ENTER_CMD),
    .EXIT_CMD (EXIT_CMD)
  ) decode_i (
    .cyc_valid_i(cyc_valid_i),
    .port_sel_i (port_sel_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .ev_o       (ev)
  );

  a20_trap_policy policy_i (
    .state_i  (state_q),
    .ev_i     (ev),
    .gov_i    (gov),
    .verdict_o(verdict)
  );

  a20_seq_reg seq_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .verdict_i(verdict),
    .state_o  (state_q),
    .fwd_o    (fwd_o),
    .smi_o    (smi_o),
    .pend_o   (pend_o)
  );

endmodule

// File: rtl/a20_gate_trap_chk.sv
module a20_gate_trap_chk #(
  parameter int unsigned       DATA_W    = 8,
  parameter logic [DATA_W-1:0] ENTER_CMD = 8'hD1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cyc_valid_i,
  input logic              port_sel_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [4:0]        gov_i,   // {exit, wr_cmd, rd_status, wr_data, rd_data}
  input logic              fwd_o,
  input logic              smi_o,
  input logic              pend_o
);

  // R2
  enter_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_i && port_sel_i && wr_i && wdata_i == ENTER_CMD && !pend_o
    |=> pend_o && fwd_o && !smi_o);

  // R3
  idle_cmd_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_i && port_sel_i && wr_i && wdata_i != ENTER_CMD && !pend_o
    |=> !pend_o && smi_o == $past(gov_i[3]) && fwd_o == !$past(gov_i[3]));

  // R8
  status_read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_i && port_sel_i && !wr_i && pend_o
    |=> pend_o && smi_o == $past(gov_i[2]) && fwd_o == !$past(gov_i[2]));

  // R7
  open_data_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_i && !port_sel_i && !wr_i && pend_o
    |=> !pend_o && fwd_o == !$past(gov_i[0]) && smi_o == ($past(gov_i[0]) || $past(gov_i[4])));

  // R13
  exit_smi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_o) && $past(gov_i[4]) |-> smi_o);

  // R14
  no_cycle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_valid_i |=> !fwd_o && !smi_o && $stable(pend_o));

  // R14
  rise_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(cyc_valid_i && wr_i && port_sel_i));

endmodule

bind a20_gate_trap a20_gate_trap_chk #(
  .DATA_W   (DATA_W),
  .ENTER_CMD(ENTER_CMD)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cyc_valid_i(cyc_valid_i),
  .port_sel_i (port_sel_i),
  .wr_i       (wr_i),
  .wdata_i    (wdata_i),
  .gov_i      ({cfg_i[BIT_EXIT_SMI], cfg_i[BIT_WR_CMD], cfg_i[BIT_RD_STATUS],
                cfg_i[BIT_WR_DATA], cfg_i[BIT_RD_DATA]}),
  .fwd_o      (fwd_o),
  .smi_o      (smi_o),
  .pend_o     (pend_o)
);

// File: tb/a20_gate_trap_tb.sv
module a20_gate_trap_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cyc_valid_i = 1'b0;
  logic       port_sel_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] cfg_i = 8'h00;
  logic       fwd_o, smi_o, pend_o;

  int checks = 0;
  int errors = 0;

  // model state: 0 idle, 1 after D1h, 2 after data byte
  int    m_st = 0;
  int    e_nxt;
  logic  e_fwd, e_smi;
  string e_tag;

  always #10 clk_i = ~clk_i;  // 50 MHz

  a20_gate_trap dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_valid_i(cyc_valid_i),
    .port_sel_i (port_sel_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .cfg_i      (cfg_i),
    .fwd_o      (fwd_o),
    .smi_o      (smi_o),
    .pend_o     (pend_o)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic gov(input logic b, input int nxt, input logic is_exit, input logic c7,
                     input string tag);
    e_nxt = nxt;
    e_fwd = !b;
    e_smi = b | (is_exit & c7);
    e_tag = (is_exit && c7) ? {tag, " R13"} : tag;
  endtask

  task automatic model(input logic ps, input logic w, input logic [7:0] d, input logic [7:0] c);
    e_nxt = m_st; e_fwd = 1'b1; e_smi = 1'b0; e_tag = "R3";
    if (m_st == 0) begin
      if (ps && w && d == 8'hD1) begin e_nxt = 1; e_tag = "R2"; end
      else if (ps && w)  gov(c[3], 0, 1'b0, c[7], "R3");
      else if (ps)       gov(c[2], 0, 1'b0, c[7], "R3");
      else if (w)        gov(c[1], 0, 1'b0, c[7], "R3");
      else               gov(c[0], 0, 1'b0, c[7], "R3");
    end else if (m_st == 1) begin
      if (ps && w && d == 8'hD1) begin e_nxt = 1; e_tag = "R5"; end
      else if (ps && w)  gov(c[3], 0, 1'b1, c[7], "R6");
      else if (ps)       gov(c[2], 1, 1'b0, c[7], "R8");
      else if (w)        begin e_nxt = 2; e_tag = "R4"; end
      else               gov(c[0], 0, 1'b1, c[7], "R7");
    end else begin
      if (ps && w && d == 8'hFF) begin
        e_nxt = 0; e_smi = c[7]; e_tag = c[7] ? "R9 R13" : "R9";
      end
      else if (ps && w)  gov(c[3], 0, 1'b1, c[7], "R10");
      else if (ps)       gov(c[2], 2, 1'b0, c[7], "R8");
      else if (w)        gov(c[1], 0, 1'b1, c[7], "R11");
      else               gov(c[0], 0, 1'b1, c[7], "R12");
    end
  endtask

  task automatic do_cycle(input logic ps, input logic w, input logic [7:0] d, input logic [7:0] c);
    @(negedge clk_i);
    cyc_valid_i = 1'b1; port_sel_i = ps; wr_i = w; wdata_i = d; cfg_i = c;
    model(ps, w, d, c);
    @(negedge clk_i);
    cyc_valid_i = 1'b0;
    cfg_i = 8'h00;
    check(fwd_o, e_fwd, e_tag, "fwd_o");
    check(smi_o, e_smi, e_tag, "smi_o");
    check(pend_o, e_nxt != 0, e_tag, "pend_o");
    m_st = e_nxt;
  endtask

  // R14: a clock with no cycle gives no pulses and holds pend_o
  task automatic gap(input logic [7:0] c);
    @(negedge clk_i);
    cyc_valid_i = 1'b0; cfg_i = c; wdata_i = 8'hD1; port_sel_i = 1'b1; wr_i = 1'b1;
    @(negedge clk_i);
    check(fwd_o, 1'b0, "R14", "fwd_o idle");
    check(smi_o, 1'b0, "R14", "smi_o idle");
    check(pend_o, m_st != 0, "R14", "pend_o hold");
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h0A20_5EED));
    // R1
    repeat (3) @(negedge clk_i);
    check(pend_o, 1'b0, "R1", "pend_o in reset");
    check(fwd_o, 1'b0, "R1", "fwd_o in reset");
    check(smi_o, 1'b0, "R1", "smi_o in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(pend_o, 1'b0, "R1", "pend_o after reset");
    check(smi_o, 1'b0, "R1", "smi_o after reset");

    // directed walk
    do_cycle(1, 1, 8'h20, 8'h08);  // R3 trapped command write
    do_cycle(0, 0, 8'h00, 8'h00);  // R3 forwarded data read
    do_cycle(1, 0, 8'h00, 8'h04);  // R3 trapped status read
    do_cycle(0, 1, 8'h55, 8'h02);  // R3 trapped data write
    do_cycle(1, 1, 8'hD1, 8'hFF);  // R2
    do_cycle(1, 1, 8'hD1, 8'hFF);  // R5 double trigger
    gap(8'hFF);
    do_cycle(1, 0, 8'h00, 8'h04);  // R8 in first state
    do_cycle(0, 1, 8'hDF, 8'hFF);  // R4
    do_cycle(1, 0, 8'h00, 8'h00);  // R8 in second state
    do_cycle(1, 1, 8'hFF, 8'h00);  // R9 without SMI
    do_cycle(1, 1, 8'hD1, 8'h00);
    do_cycle(0, 1, 8'hDD, 8'h00);
    do_cycle(1, 1, 8'hFF, 8'h80);  // R9 with R13
    do_cycle(1, 1, 8'hD1, 8'h00);
    do_cycle(1, 1, 8'h12, 8'h08);  // R6
    do_cycle(1, 1, 8'hD1, 8'h00);
    do_cycle(0, 0, 8'h00, 8'h80);  // R7 forwarded, R13 SMI
    do_cycle(1, 1, 8'hD1, 8'h00);
    do_cycle(0, 1, 8'hDF, 8'h00);
    do_cycle(1, 1, 8'hD1, 8'h08);  // R10
    do_cycle(1, 1, 8'hD1, 8'h00);
    do_cycle(0, 1, 8'hDF, 8'h00);
    do_cycle(0, 1, 8'h00, 8'h02);  // R11
    do_cycle(1, 1, 8'hD1, 8'h00);
    do_cycle(0, 1, 8'hDF, 8'h00);
    do_cycle(0, 0, 8'h00, 8'h81);  // R12 with R13
    gap(8'h00);

    // weighted random
    for (int i = 0; i < 6000; i++) begin
      int unsigned sel;
      logic [7:0] c;
      sel = $urandom_range(0, 9);
      c = 8'($urandom());
      case (sel)
        0, 1, 2: do_cycle(1, 1, 8'hD1, c);
        3, 4:    do_cycle(0, 1, 8'($urandom()), c);
        5:       do_cycle(1, 1, 8'hFF, c);
        6:       do_cycle(1, 1, 8'($urandom()), c);
        7:       do_cycle(0, 0, 8'($urandom()), c);
        8:       do_cycle(1, 0, 8'($urandom()), c);
        default: gap(c);
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule